// File: doc/BRIEF.md
# Semaphore-guarded power domain controller

This block is the shared power controller used by three processor domains (RT, SYS and BB). Each domain has its own register port with four registers. All ports act on one common set of state: a 2-bit ownership semaphore, a power-down mask with one bit per power domain, and a sticky error flag for each port. A domain must first win the semaphore. Only the domain that holds it may change the power-down mask or release the semaphore. Any write that the block refuses is dropped and sets the writing port's error flag.

Each power domain has its own sequencer, so one domain can be switched off while the others keep running. Switching a domain off raises isolation first and removes power after a short hold. Switching it on restores power first and releases isolation after a settle time. A separate wake-up register lets any port, semaphore or not, clear the power-down bit of a domain that is off. That domain then starts its power-up sequence.

The register offsets are the same on every port. Offset 0 is the semaphore. Offset 1 is the power-down mask, where bit d set to 1 requests that domain d be off. Offset 2 is wake-up on write and on-status on read; on read, bit d is 1 when domain d is powered and not isolated. Offset 3 is the error flag in bit 0; a write to offset 3 clears that port's flag. Port 0 is RT, port 1 is SYS and port 2 is BB.

Each domain sequencer has four states:
- SQ_ON: power on, isolation off.
- SQ_ISOLATE: power on, isolation on.
- SQ_OFF: power off, isolation on.
- SQ_SETTLE: power on, isolation on.

The sequencer moves between them as follows:
- SQ_ON goes to SQ_ISOLATE when the domain's mask bit is 1.
- SQ_ISOLATE goes to SQ_OFF after ISO_WAIT cycles.
- SQ_OFF goes to SQ_SETTLE when the mask bit is 0.
- SQ_SETTLE goes to SQ_ON after SETTLE_CYC cycles.
- A sequence that has started always runs to its end.

Top module: `pwrsem_ctrl`

## Requirements
- R1: After reset the semaphore reads 00, the power-down mask reads 0, every error flag reads 0, and every domain has pwr_en=1 and iso_en=0.
- R2: Owner codes are 01 for RT (port 0), 10 for SYS (port 1) and 11 for BB (port 2). A port that writes its own code to offset 0 while the semaphore is 00 becomes the owner on the next cycle, and every port then reads that code back.
- R3: When several ports write their own codes to the free semaphore in the same cycle, RT wins over SYS and SYS wins over BB. Writing one's own code while another port holds the semaphore has no effect and sets no error.
- R4: Only the owner's write to offset 1 replaces the power-down mask. A mask write from any other port leaves the mask and all outputs unchanged.
- R5: The owner releases the semaphore by writing 00. A 00 written by a non-owner, or another port's code written by any port, leaves the semaphore unchanged.
- R6: When a domain's mask bit is set, its iso_en rises on the second clock edge after the write. Its pwr_en falls 2 edges after that, while iso_en stays 1.
- R7: When a domain's mask bit is cleared while it is off, its pwr_en rises on the second clock edge after the write. Its iso_en falls 4 edges after that.
- R8: Each refused write from R4 and R5 sets that port's sticky error flag (offset 3, bit 0) and no other port's flag. The flag stays set until that port writes to offset 3.
- R9: A write to offset 2 from any port, without the semaphore, clears each mask bit that is 1 in its data, and the domains concerned power up. It sets no error. When it meets an owner's mask write in the same cycle, the wake bits win.
- R10: A sequence on one domain leaves the pwr_en and iso_en of every other domain unchanged.
- R11: Reads of offsets 0 and 1 return the same common values on every port. On read, offset 2 returns the on-status mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 3 | Write strobe, one per port (0 RT, 1 SYS, 2 BB) |
| wr_addr | input | 6 | Write offset, 2 bits per port |
| wr_data | input | 3*DW | Write data, DW bits per port |
| rd_addr | input | 6 | Read offset, 2 bits per port |
| rd_data | output | 3*DW | Combinational read data, DW bits per port |
| pwr_en | output | N_DOM | Power enable per domain |
| iso_en | output | N_DOM | Isolation enable per domain |

## Verification
The bench builds the block with its defaults: N_DOM=4 (so DW=4), ISO_WAIT=2 and SETTLE_CYC=4. Four domains are enough to power two down together, wake one of them and keep the other off, while a fourth domain stays on as an untouched bystander. The short waits let the bench check every cycle of both sequences against the exact edge counts in R6 and R7.

// File: rtl/pwrsem_pkg.sv
package pwrsem_pkg;
    localparam int N_PORT = 3;
    localparam int AW     = 2;

    localparam logic [1:0] OWN_FREE = 2'b00;

    localparam logic [1:0] OFS_SEM  = 2'd0;
    localparam logic [1:0] OFS_PD   = 2'd1;
    localparam logic [1:0] OFS_WAKE = 2'd2;
    localparam logic [1:0] OFS_ERR  = 2'd3;

    typedef enum logic [1:0] {
        SQ_ON,
        SQ_ISOLATE,
        SQ_OFF,
        SQ_SETTLE
    } seq_state_t;
endpackage

// File: rtl/pwrsem_arb.sv
module pwrsem_arb
    import pwrsem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PORT-1:0] sem_wr,
    input  logic [2*N_PORT-1:0] sem_val,
    input  logic [N_PORT-1:0] pd_wr,
    input  logic [N_PORT-1:0] err_clr,
    output logic [1:0]        sem_q,
    output logic [N_PORT-1:0] owner_oh,
    output logic [N_PORT-1:0] err_q
);
    logic [1:0]        sem_d;
    logic [N_PORT-1:0] err_d;
    logic [N_PORT-1:0] acq_hit;
    logic [N_PORT-1:0] bad_wr;

    always_comb begin
        sem_d   = sem_q;
        acq_hit = '0;
        bad_wr  = '0;
        for (int p = N_PORT - 1; p >= 0; p--) begin
            logic [1:0] code;
            logic [1:0] val;
            code = 2'(p + 1);
            val  = sem_val[2*p +: 2];
            owner_oh[p] = (sem_q == code);
            if (sem_wr[p] && val == code && sem_q == OWN_FREE) begin
                acq_hit[p] = 1'b1;
                sem_d      = code;
            end
            if (sem_wr[p] && val == OWN_FREE && owner_oh[p]) begin
                sem_d = OWN_FREE;
            end
            bad_wr[p] = (sem_wr[p] && ((val == OWN_FREE && !owner_oh[p]) ||
                                       (val != OWN_FREE && val != code))) ||
                        (pd_wr[p] && !owner_oh[p]);
        end
        for (int p = 0; p < N_PORT; p++) begin
            if (bad_wr[p]) begin
                err_d[p] = 1'b1;
            end else if (err_clr[p]) begin
                err_d[p] = 1'b0;
            end else begin
                err_d[p] = err_q[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sem_q <= OWN_FREE;
            err_q <= '0;
        end else begin
            sem_q <= sem_d;
            err_q <= err_d;
        end
    end

    // R3: RT acquire attempt on a free semaphore always wins
    p_rt_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acq_hit[0]) |-> sem_q == 2'b01);

    // R5: a held semaphore only ever returns to free, never passes directly
    p_owner_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sem_q) != OWN_FREE && sem_q != $past(sem_q)) |-> sem_q == OWN_FREE);

    // R2: leaving free requires an acquire attempt in the previous cycle
    p_acquire_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sem_q) == OWN_FREE && sem_q != OWN_FREE) |-> $past(acq_hit) != '0);

    for (genvar g = 0; g < N_PORT; g++) begin : g_err_chk
        // R8: flag stays set until its own port clears it
        p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(err_q[g]) && !$past(err_clr[g])) |-> err_q[g]);
    end
endmodule

// File: rtl/pwrsem_seq.sv
module pwrsem_seq
    import pwrsem_pkg::*;
#(
    parameter int ISO_WAIT   = 2,
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic off_req,
    output logic pwr_en,
    output logic iso_en
);
    localparam int MAXW = (ISO_WAIT > SETTLE_CYC) ? ISO_WAIT : SETTLE_CYC;
    localparam int CW   = $clog2(MAXW + 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SQ_ON: begin
                if (off_req) begin
                    state_d = SQ_ISOLATE;
                    cnt_d   = '0;
                end
            end
            SQ_ISOLATE: begin
                if (cnt_q == CW'(ISO_WAIT - 1)) begin
                    state_d = SQ_OFF;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SQ_OFF: begin
                if (!off_req) begin
                    state_d = SQ_SETTLE;
                    cnt_d   = '0;
                end
            end
            SQ_SETTLE: begin
                if (cnt_q == CW'(SETTLE_CYC - 1)) begin
                    state_d = SQ_ON;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = SQ_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_ON;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SQ_ON:      begin pwr_en = 1'b1; iso_en = 1'b0; end
            SQ_ISOLATE: begin pwr_en = 1'b1; iso_en = 1'b1; end
            SQ_OFF:     begin pwr_en = 1'b0; iso_en = 1'b1; end
            SQ_SETTLE:  begin pwr_en = 1'b1; iso_en = 1'b1; end
            default:    begin pwr_en = 1'b1; iso_en = 1'b0; end
        endcase
    end

    // R6: power is removed only after isolation has been held
    p_iso_before_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> (iso_en && $past(iso_en)));

    // R7: isolation is released only with power present for at least a cycle
    p_power_before_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> (pwr_en && $past(pwr_en)));

    // R6: a powered-off domain is always isolated
    p_off_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> iso_en);
endmodule

// File: rtl/pwrsem_ctrl.sv
module pwrsem_ctrl
    import pwrsem_pkg::*;
#(
    parameter int N_DOM      = 4,
    parameter int ISO_WAIT   = 2,
    parameter int SETTLE_CYC = 4,
    localparam int DW        = (N_DOM > 2) ? N_DOM : 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_PORT-1:0]    wr_en,
    input  logic [N_PORT*AW-1:0] wr_addr,
    input  logic [N_PORT*DW-1:0] wr_data,
    input  logic [N_PORT*AW-1:0] rd_addr,
    output logic [N_PORT*DW-1:0] rd_data,
    output logic [N_DOM-1:0]     pwr_en,
    output logic [N_DOM-1:0]     iso_en
);
    logic [N_PORT-1:0]   sem_wr, pd_wr, wake_wr, err_clr;
    logic [2*N_PORT-1:0] sem_val;
    logic [1:0]          sem_q;
    logic [N_PORT-1:0]   owner_oh, err_q;
    logic [N_DOM-1:0]    pd_q, pd_d, wake_all;
    logic                pd_ok;

    always_comb begin
        for (int p = 0; p < N_PORT; p++) begin
            sem_wr[p]  = wr_en[p] && (wr_addr[AW*p +: AW] == OFS_SEM);
            pd_wr[p]   = wr_en[p] && (wr_addr[AW*p +: AW] == OFS_PD);
            wake_wr[p] = wr_en[p] && (wr_addr[AW*p +: AW] == OFS_WAKE);
            err_clr[p] = wr_en[p] && (wr_addr[AW*p +: AW] == OFS_ERR);
            sem_val[2*p +: 2] = wr_data[DW*p +: 2];
        end
    end

    pwrsem_arb i_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .sem_wr   (sem_wr),
        .sem_val  (sem_val),
        .pd_wr    (pd_wr),
        .err_clr  (err_clr),
        .sem_q    (sem_q),
        .owner_oh (owner_oh),
        .err_q    (err_q)
    );

    always_comb begin
        pd_d     = pd_q;
        pd_ok    = 1'b0;
        wake_all = '0;
        for (int p = 0; p < N_PORT; p++) begin
            if (pd_wr[p] && owner_oh[p]) begin
                pd_d  = wr_data[DW*p +: N_DOM];
                pd_ok = 1'b1;
            end
            if (wake_wr[p]) begin
                wake_all = wake_all | wr_data[DW*p +: N_DOM];
            end
        end
        pd_d = pd_d & ~wake_all;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q <= '0;
        end else begin
            pd_q <= pd_d;
        end
    end

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        pwrsem_seq #(
            .ISO_WAIT   (ISO_WAIT),
            .SETTLE_CYC (SETTLE_CYC)
        ) i_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .off_req (pd_q[d]),
            .pwr_en  (pwr_en[d]),
            .iso_en  (iso_en[d])
        );
    end

    always_comb begin
        for (int p = 0; p < N_PORT; p++) begin
            unique case (rd_addr[AW*p +: AW])
                OFS_SEM:  rd_data[DW*p +: DW] = DW'(sem_q);
                OFS_PD:   rd_data[DW*p +: DW] = DW'(pd_q);
                OFS_WAKE: rd_data[DW*p +: DW] = DW'(pwr_en & ~iso_en);
                default:  rd_data[DW*p +: DW] = DW'(err_q[p]);
            endcase
        end
    end

    // R4: a newly set mask bit needs an owner mask write in the previous cycle
    p_pd_owner_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pd_q & ~$past(pd_q))) |-> $past(pd_ok));

    // R9: a woken domain never has its mask bit set in the next cycle
    p_wake_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wake_all) != '0 |-> (pd_q & $past(wake_all)) == '0);
endmodule

// File: tb/test_pwrsem_ctrl.sv
module test_pwrsem_ctrl;
    localparam int NP = 3;
    localparam int ND = 4;
    localparam int DW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   wr_en = '0;
    logic [NP*2-1:0] wr_addr = '0;
    logic [NP*DW-1:0] wr_data = '0;
    logic [NP*2-1:0] rd_addr = '0;
    logic [NP*DW-1:0] rd_data;
    logic [ND-1:0]   pwr_en, iso_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwrsem_ctrl i_pwrsem_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pwr_en  (pwr_en),
        .iso_en  (iso_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_wr(input int p, input int a, input int d);
        wr_en[p] = 1'b1;
        wr_addr[2*p +: 2] = 2'(a);
        wr_data[DW*p +: DW] = DW'(d);
    endtask

    task automatic tick();
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic wr(input int p, input int a, input int d);
        set_wr(p, a, d);
        tick();
    endtask

    task automatic rd(input int p, input int a, output int v);
        rd_addr[2*p +: 2] = 2'(a);
        #1;
        v = int'(rd_data[DW*p +: DW]);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        for (int p = 0; p < NP; p++) begin
            rd(p, 0, v); chk("R1 sem at reset", v, 0);
            rd(p, 3, v); chk("R1 err at reset", v, 0);
        end
        rd(0, 1, v); chk("R1 mask at reset", v, 0);
        chk("R1 pwr_en at reset", int'(pwr_en), 15);
        chk("R1 iso_en at reset", int'(iso_en), 0);
        rd(2, 2, v); chk("R11 on-status at reset", v, 15);
    endtask

    task automatic t_acquire_release();
        int v;
        wr(1, 0, 2);
        for (int p = 0; p < NP; p++) begin
            rd(p, 0, v); chk("R2 R11 SYS owns, seen on all ports", v, 2);
        end
        wr(0, 0, 1);
        rd(0, 0, v); chk("R3 acquire while held ignored", v, 2);
        rd(0, 3, v); chk("R3 failed acquire sets no error", v, 0);
        wr(2, 0, 0);
        rd(2, 0, v); chk("R5 non-owner release ignored", v, 2);
        rd(2, 3, v); chk("R8 BB error set", v, 1);
        rd(0, 3, v); chk("R8 RT error untouched", v, 0);
        wait_cyc(3);
        rd(2, 3, v); chk("R8 BB error sticky", v, 1);
        wr(2, 3, 0);
        rd(2, 3, v); chk("R8 BB error cleared", v, 0);
        wr(1, 0, 0);
        rd(2, 0, v); chk("R5 owner release", v, 0);
        wr(0, 0, 3);
        rd(0, 0, v); chk("R5 foreign code ignored", v, 0);
        rd(0, 3, v); chk("R8 foreign code error", v, 1);
        wr(0, 3, 0);
        wr(2, 0, 3);
        rd(1, 0, v); chk("R2 BB acquires", v, 3);
        wr(2, 0, 0);
        rd(1, 0, v); chk("R5 BB release", v, 0);
    endtask

    task automatic t_priority();
        int v;
        set_wr(0, 0, 1); set_wr(1, 0, 2); set_wr(2, 0, 3); tick();
        rd(1, 0, v); chk("R3 RT wins three-way", v, 1);
        wr(0, 0, 0);
        set_wr(1, 0, 2); set_wr(2, 0, 3); tick();
        rd(0, 0, v); chk("R3 SYS wins over BB", v, 2);
        rd(2, 3, v); chk("R3 loser has no error", v, 0);
        wr(1, 0, 0);
    endtask

    task automatic t_power_seq();
        int v;
        wr(1, 0, 2);
        wr(0, 1, 1);
        rd(0, 1, v); chk("R4 non-owner mask write ignored", v, 0);
        rd(0, 3, v); chk("R8 non-owner mask write error", v, 1);
        wait_cyc(4);
        chk("R4 outputs unchanged", int'(pwr_en), 15);
        wr(0, 3, 0);
        wr(1, 1, 2);
        rd(2, 1, v); chk("R11 mask visible on BB", v, 2);
        chk("R6 edge0 iso", int'(iso_en[1]), 0);
        wait_cyc(1);
        chk("R6 edge1 iso up", int'(iso_en[1]), 1);
        chk("R6 edge1 pwr", int'(pwr_en[1]), 1);
        wait_cyc(1);
        chk("R6 edge2 pwr held", int'(pwr_en[1]), 1);
        wait_cyc(1);
        chk("R6 edge3 pwr off", int'(pwr_en[1]), 0);
        chk("R6 edge3 iso held", int'(iso_en[1]), 1);
        chk("R10 other domains pwr", int'(pwr_en), 13);
        chk("R10 other domains iso", int'(iso_en), 2);
        rd(1, 2, v); chk("R11 on-status with domain1 off", v, 13);
        wr(1, 1, 0);
        chk("R7 edge0 pwr still off", int'(pwr_en[1]), 0);
        wait_cyc(1);
        chk("R7 edge1 pwr up", int'(pwr_en[1]), 1);
        for (int k = 1; k <= 3; k++) begin
            chk("R7 settle keeps iso", int'(iso_en[1]), 1);
            wait_cyc(1);
        end
        chk("R7 edge4 iso held", int'(iso_en[1]), 1);
        wait_cyc(1);
        chk("R7 edge5 iso released", int'(iso_en[1]), 0);
        chk("R10 all on again", int'(pwr_en), 15);
        wr(1, 0, 0);
    endtask

    task automatic t_wake();
        int v;
        wr(1, 0, 2);
        wr(1, 1, 12);
        wait_cyc(5);
        chk("R6 domains 2 3 off", int'(pwr_en), 3);
        wr(1, 0, 0);
        wr(2, 2, 4);
        rd(0, 1, v); chk("R9 wake clears bit without sem", v, 8);
        rd(2, 3, v); chk("R9 wake sets no error", v, 0);
        wait_cyc(6);
        chk("R9 domain2 powered", int'(pwr_en), 7);
        chk("R9 domain2 not isolated", int'(iso_en), 8);
        wr(0, 2, 1);
        rd(0, 1, v); chk("R9 wake of on domain no effect", v, 8);
        chk("R9 domain0 still on", int'(pwr_en[0]), 1);
        wr(1, 0, 2);
        set_wr(1, 1, 15); set_wr(0, 2, 8); tick();
        rd(1, 1, v); chk("R9 wake wins over owner write", v, 7);
        wait_cyc(8);
        chk("R9 domain3 up, others off", int'(pwr_en), 8);
        wr(1, 1, 0);
        wait_cyc(8);
        chk("R7 all restored", int'(iso_en), 0);
        wr(1, 0, 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_acquire_release();
        t_priority();
        t_power_seq();
        t_wake();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule